// File: doc/BRIEF.md
# Banked Scratch RAM and Address-Space Decoder

This block holds the 256-byte on-chip working RAM of an 8-bit accumulator-style controller and decides, for every request, where an 8-bit address actually lands. Four request kinds share one port. Direct byte accesses reach the lower half of RAM, or the special-function-register port when the address is 80h or above. Indirect byte accesses take their address from working register R0 or R1 of the current bank and reach all 256 bytes, so stack pushes and pops use them. Register accesses name one of eight working registers in the bank picked by two status-word bits. Single-bit accesses fold a bit address onto a 16-byte window of RAM, or pass it to the SFR port as a bit operation.

A request is presented for one cycle with `req_valid`. SFR strobes come out in the same cycle. Read data, whether from RAM or from `sfr_rdata`, appears one cycle later with `rd_valid`. Every request returns the value the location held before the request, writes included. A bit write updates the addressed bit and leaves the other seven bits of the byte unchanged.

Top module: `idm_ctrl`

## Requirements
- R1: A direct request (mode 0) with address 00h–7Fh reads or writes the RAM byte at that address and raises no SFR request.
- R2: A direct request with address 80h–FFh leaves RAM untouched and drives `sfr_req`=1 in the same cycle, with `sfr_addr` = address, `sfr_we` = `req_we`, `sfr_wdata` = `req_wdata` and `sfr_bit_en`=0. One cycle later `rd_data` holds the `sfr_rdata` value sampled with the request.
- R3: An indirect request (mode 1) uses as its address the RAM byte at {3'b000, psw[4:3], 2'b00, req_ptr_sel}, which is R0 or R1 of the current bank. It reaches any of the 256 bytes and never raises `sfr_req`.
- R4: A register request (mode 2) accesses RAM address {3'b000, psw[4], psw[3], req_addr[2:0]}.
- R5: A bit request (mode 3) with bit address b below 80h accesses bit b[2:0] of RAM byte 20h + b[6:3]. A bit write sets that bit to `req_wbit` and leaves the other seven bits unchanged.
- R6: A bit request with b of 80h or above leaves RAM untouched and drives `sfr_req`=1 and `sfr_bit_en`=1, with `sfr_addr` = {b[7:3], 3'b000}, `sfr_bit_pos` = b[2:0], `sfr_we` = `req_we` and `sfr_wbit` = `req_wbit`.
- R7: One cycle after any request `rd_valid` is 1. `rd_data` then holds the byte's value from before the request, even when the request was a write. `rd_bit` holds the addressed bit of that byte for bit requests, and 0 otherwise.
- R8: During reset `rd_valid`, `rd_data` and `rd_bit` are 0, and `sfr_req` is 0 while `req_valid` is low.
- R9: A cycle with `req_valid` low changes no RAM byte, even when `req_we` is high, raises no `sfr_req`, and gives `rd_valid`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 register, 3 bit |
| req_we | input | 1 | Write when high, read when low |
| req_addr | input | 8 | Direct address, register number in [2:0], or bit address |
| req_ptr_sel | input | 1 | Indirect pointer select: 0 R0, 1 R1 |
| req_wdata | input | 8 | Byte write data |
| req_wbit | input | 1 | Bit write value |
| psw | input | 8 | Status word; bits 4:3 select the register bank |
| rd_valid | output | 1 | Read data valid, one cycle after a request |
| rd_data | output | 8 | Byte value from before the request |
| rd_bit | output | 1 | Addressed bit from before a bit request |
| sfr_req | output | 1 | SFR access strobe |
| sfr_we | output | 1 | SFR write |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR byte write data |
| sfr_bit_en | output | 1 | SFR access is a single-bit operation |
| sfr_bit_pos | output | 3 | Bit position for SFR bit operations |
| sfr_wbit | output | 1 | SFR bit write value |
| sfr_rdata | input | 8 | SFR read data, sampled with the request |

## Verification
The bench targets the address 80h, which a direct request sends to the SFR port while an indirect request with the same pointer value reads RAM. A decoder that keys off the address alone would corrupt one of the two paths. Bit addresses 7Fh and 80h sit on either side of the RAM/SFR fold, and bank 3's R1 is used as a pointer that overwrites itself. A wrong bank field or a stale pointer read shows up there as data landing at the wrong byte. Writes are checked for returning the old contents, bit writes for disturbing neighbouring bits, and idle cycles with write enable high for modifying memory, each against a bench-side shadow of all 256 bytes.

// File: rtl/idm_pkg.sv
package idm_pkg;

  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int BANK_W    = 2;
  localparam int REG_IDX_W = 3;
  localparam int BITPOS_W  = 3;
  localparam int RS_LSB    = 3;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_REGISTER = 2'd2,
    AM_BIT      = 2'd3
  } am_e;

  // Working-register bank chosen by the status word.
  function automatic logic [BANK_W-1:0] bank_of(input logic [BYTE_W-1:0] status);
    return status[RS_LSB +: BANK_W];
  endfunction

  // RAM address of working register idx in bank bk.
  function automatic logic [ADDR_W-1:0] reg_loc(input logic [BANK_W-1:0] bk,
                                                input logic [REG_IDX_W-1:0] idx);
    return {{(ADDR_W-BANK_W-REG_IDX_W){1'b0}}, bk, idx};
  endfunction

  // Byte that holds a bit address in the bit-addressable RAM window.
  function automatic logic [ADDR_W-1:0] bit_home(input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] baddr);
    return base + {{(ADDR_W-4){1'b0}}, baddr[6:3]};
  endfunction

  // SFR byte address for a bit address in the upper half.
  function automatic logic [ADDR_W-1:0] sfr_bit_home(input logic [ADDR_W-1:0] baddr);
    return {baddr[ADDR_W-1:BITPOS_W], {BITPOS_W{1'b0}}};
  endfunction

  // Byte with one bit replaced.
  function automatic logic [BYTE_W-1:0] put_bit(input logic [BYTE_W-1:0] b,
                                                input logic [BITPOS_W-1:0] pos,
                                                input logic val);
    logic [BYTE_W-1:0] r;
    r = b;
    r[pos] = val;
    return r;
  endfunction

endpackage

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic [1:0]          mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ptr_sel,
  input  logic [BYTE_W-1:0]   status,
  input  logic [BYTE_W-1:0]   ptr_val,
  output logic [ADDR_W-1:0]   ptr_loc,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [ADDR_W-1:0]   sfr_addr,
  output logic                sfr_sel,
  output logic                is_bit,
  output logic [BITPOS_W-1:0] bit_pos
);

  logic [BANK_W-1:0] bank;
  am_e               am;

  assign bank    = bank_of(status);
  assign am      = am_e'(mode);
  assign ptr_loc = reg_loc(bank, {2'b00, ptr_sel});
  assign bit_pos = addr[BITPOS_W-1:0];

  always_comb begin
    ram_addr = addr;
    sfr_addr = addr;
    sfr_sel  = 1'b0;
    is_bit   = 1'b0;
    unique case (am)
      AM_DIRECT: begin
        sfr_sel  = addr[ADDR_W-1];
        ram_addr = {1'b0, addr[ADDR_W-2:0]};
      end
      AM_INDIRECT: begin
        ram_addr = ptr_val;
      end
      AM_REGISTER: begin
        ram_addr = reg_loc(bank, addr[REG_IDX_W-1:0]);
      end
      AM_BIT: begin
        is_bit   = 1'b1;
        sfr_sel  = addr[ADDR_W-1];
        ram_addr = bit_home(BIT_BASE, addr);
        sfr_addr = sfr_bit_home(addr);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    ptr_addr,
  output logic [WIDTH-1:0] ptr_data,
  input  logic [AW-1:0]    acc_addr,
  output logic [WIDTH-1:0] acc_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Two asynchronous read ports: pointer fetch and data access.
  assign ptr_data = mem[ptr_addr];
  assign acc_data = mem[acc_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

endmodule

// File: rtl/idm_resp.sv
module idm_resp
  import idm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              bit_in,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_bit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_bit   <= 1'b0;
    end else begin
      rd_valid <= fire;
      if (fire) begin
        rd_data <= byte_in;
        rd_bit  <= bit_in;
      end
    end
  end

endmodule

// File: rtl/idm_ctrl.sv
module idm_ctrl
  import idm_pkg::*;
#(
  parameter int                DEPTH    = 256,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_mode,
  input  logic        req_we,
  input  logic [7:0]  req_addr,
  input  logic        req_ptr_sel,
  input  logic [7:0]  req_wdata,
  input  logic        req_wbit,
  input  logic [7:0]  psw,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        rd_bit,
  output logic        sfr_req,
  output logic        sfr_we,
  output logic [7:0]  sfr_addr,
  output logic [7:0]  sfr_wdata,
  output logic        sfr_bit_en,
  output logic [2:0]  sfr_bit_pos,
  output logic        sfr_wbit,
  input  logic [7:0]  sfr_rdata
);

  localparam int RAM_AW = $clog2(DEPTH);

  // Internal events, named for the checker.
  logic [ADDR_W-1:0]   ptr_loc;
  logic [BYTE_W-1:0]   ptr_val;
  logic [ADDR_W-1:0]   ram_addr;
  logic [ADDR_W-1:0]   dec_sfr_addr;
  logic                sfr_sel;
  logic                is_bit;
  logic [BITPOS_W-1:0] bit_pos;
  logic [BYTE_W-1:0]   ram_old;
  logic [BYTE_W-1:0]   ram_new;
  logic                ram_we;
  logic [BYTE_W-1:0]   old_byte;

  idm_decode #(.BIT_BASE(BIT_BASE)) i_decode (
    .mode     (req_mode),
    .addr     (req_addr),
    .ptr_sel  (req_ptr_sel),
    .status   (psw),
    .ptr_val  (ptr_val),
    .ptr_loc  (ptr_loc),
    .ram_addr (ram_addr),
    .sfr_addr (dec_sfr_addr),
    .sfr_sel  (sfr_sel),
    .is_bit   (is_bit),
    .bit_pos  (bit_pos)
  );

  assign ram_we  = req_valid & req_we & ~sfr_sel;
  assign ram_new = is_bit ? put_bit(ram_old, bit_pos, req_wbit) : req_wdata;

  idm_ram #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) i_ram (
    .clk      (clk),
    .wr_en    (ram_we),
    .wr_addr  (ram_addr[RAM_AW-1:0]),
    .wr_data  (ram_new),
    .ptr_addr (ptr_loc[RAM_AW-1:0]),
    .ptr_data (ptr_val),
    .acc_addr (ram_addr[RAM_AW-1:0]),
    .acc_data (ram_old)
  );

  assign sfr_req     = req_valid & sfr_sel;
  assign sfr_we      = sfr_req & req_we;
  assign sfr_addr    = dec_sfr_addr;
  assign sfr_wdata   = req_wdata;
  assign sfr_bit_en  = sfr_req & is_bit;
  assign sfr_bit_pos = bit_pos;
  assign sfr_wbit    = req_wbit;

  assign old_byte = sfr_sel ? sfr_rdata : ram_old;

  idm_resp i_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (req_valid),
    .byte_in  (old_byte),
    .bit_in   (is_bit & old_byte[bit_pos]),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_bit   (rd_bit)
  );

endmodule

// File: rtl/idm_ctrl_checker.sv
module idm_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_mode,
  input logic       req_addr7,
  input logic [7:0] psw,
  input logic       sfr_req,
  input logic [7:0] sfr_addr,
  input logic       sfr_bit_en,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [7:0] sfr_rdata,
  input logic [7:0] ram_addr,
  input logic       ram_we
);

  p_direct_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd0) |-> (sfr_req == req_addr7));

  p_sfr_data_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd0 && req_addr7) |=> (rd_data == $past(sfr_rdata)));

  p_indirect_ram_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd1) |-> !sfr_req);

  p_bank_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd2) |-> (ram_addr[7:5] == 3'b000 && ram_addr[4:3] == psw[4:3]));

  p_bit_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd3 && !req_addr7) |-> (ram_addr[7:4] == 4'h2 && !sfr_req));

  p_sfr_bit_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_bit_en |-> (sfr_req && sfr_addr[2:0] == 3'b000));

  p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rd_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!ram_we && !sfr_req));

  p_idle_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rd_valid);

endmodule

bind idm_ctrl idm_ctrl_checker i_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .req_addr7  (req_addr[7]),
  .psw        (psw),
  .sfr_req    (sfr_req),
  .sfr_addr   (sfr_addr),
  .sfr_bit_en (sfr_bit_en),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .sfr_rdata  (sfr_rdata),
  .ram_addr   (ram_addr),
  .ram_we     (ram_we)
);

// File: tb/test_idm_ctrl.sv
module test_idm_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic       req_we = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic       req_ptr_sel = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       req_wbit = 1'b0;
  logic [7:0] psw = 8'h00;
  logic [7:0] sfr_rdata = 8'h00;
  logic       rd_valid, rd_bit, sfr_req, sfr_we, sfr_bit_en, sfr_wbit;
  logic [7:0] rd_data, sfr_addr, sfr_wdata;
  logic [2:0] sfr_bit_pos;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  idm_ctrl i_idm_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_we(req_we), .req_addr(req_addr), .req_ptr_sel(req_ptr_sel),
    .req_wdata(req_wdata), .req_wbit(req_wbit), .psw(psw),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit),
    .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_bit_en(sfr_bit_en), .sfr_bit_pos(sfr_bit_pos),
    .sfr_wbit(sfr_wbit), .sfr_rdata(sfr_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Bench-side address arithmetic, written from the requirements.
  function automatic logic [7:0] bank_base(input logic [7:0] p);
    return p & 8'h18;
  endfunction

  function automatic string mode_tag(input logic [1:0] m, input bit to_sfr);
    case (m)
      2'd0:    return to_sfr ? "R2" : "R1";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return to_sfr ? "R6" : "R5";
    endcase
  endfunction

  task automatic do_op(input logic [1:0] m, input logic w, input logic [7:0] a,
                       input logic s, input logic [7:0] wd, input logic wb,
                       input logic [7:0] p);
    logic [7:0] tgt;
    logic [7:0] old;
    logic [7:0] srd;
    logic [2:0] pos;
    bit         to_sfr;
    string      tag;
    srd    = 8'($urandom);
    pos    = a[2:0];
    to_sfr = 1'b0;
    case (m)
      2'd0: begin tgt = a; to_sfr = (a >= 8'd128); end
      2'd1: tgt = shadow[bank_base(p) | {7'd0, s}];
      2'd2: tgt = bank_base(p) + (a % 8);
      default: begin
        if (a < 8'd128) tgt = 8'h20 + a / 8;
        else begin tgt = a & 8'hF8; to_sfr = 1'b1; end
      end
    endcase
    tag = mode_tag(m, to_sfr);
    req_valid = 1'b1; req_mode = m; req_we = w; req_addr = a; req_ptr_sel = s;
    req_wdata = wd; req_wbit = wb; psw = p; sfr_rdata = srd;
    #1;
    check(sfr_req == to_sfr, tag, sfr_req, to_sfr);
    if (to_sfr) begin
      check(sfr_addr == tgt && sfr_we == w, tag, {sfr_we, sfr_addr}, {w, tgt});
      check(sfr_bit_en == (m == 2'd3), tag, sfr_bit_en, m == 2'd3);
      if (m == 2'd3) check(sfr_bit_pos == pos && sfr_wbit == wb, "R6", {sfr_wbit, sfr_bit_pos}, {wb, pos});
      else check(sfr_wdata == wd, "R2", sfr_wdata, wd);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    old = to_sfr ? srd : shadow[tgt];
    check(rd_valid == 1'b1, "R7", rd_valid, 1);
    check(rd_data == old, {tag, "/R7"}, rd_data, old);
    check(rd_bit == ((m == 2'd3) ? old[pos] : 1'b0), {tag, "/R7 bit"}, rd_bit, (m == 2'd3) ? old[pos] : 1'b0);
    if (!to_sfr && w) begin
      if (m == 2'd3) shadow[tgt][pos] = wb;
      else shadow[tgt] = wd;
    end
  endtask

  task automatic do_idle(input logic [7:0] a, input logic [7:0] wd);
    req_valid = 1'b0; req_we = 1'b1; req_mode = 2'($urandom); req_addr = a; req_wdata = wd;
    #1;
    check(sfr_req == 1'b0, "R9", sfr_req, 0);
    @(posedge clk); #1;
    check(rd_valid == 1'b0, "R9", rd_valid, 0);
    req_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check(rd_valid == 1'b0 && rd_data == 8'h00 && rd_bit == 1'b0, "R8", {rd_valid, rd_data, rd_bit}, 0);
    check(sfr_req == 1'b0, "R8", sfr_req, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Fill every byte: load bank 3 R1 (address 19h) as pointer, then write through it.
    for (int i = 0; i < 256; i++) begin
      do_op(2'd2, 1'b1, 8'd1, 1'b0, 8'(i), 1'b0, 8'h18);
      do_op(2'd1, 1'b1, 8'h00, 1'b1, 8'($urandom), 1'b0, 8'h18);
    end

    // R2 vs R3: address 80h direct goes to the SFR port, indirect reads RAM.
    do_op(2'd0, 1'b1, 8'h80, 1'b0, 8'hA5, 1'b0, 8'h00);
    do_op(2'd2, 1'b1, 8'd0, 1'b0, 8'h80, 1'b0, 8'h00);
    do_op(2'd1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    do_op(2'd0, 1'b0, 8'h7F, 1'b0, 8'h00, 1'b0, 8'h00);
    // R4: bank 2 register 5 lands at 15h; read it back directly.
    do_op(2'd2, 1'b1, 8'd5, 1'b0, 8'h3C, 1'b0, 8'h10);
    do_op(2'd0, 1'b0, 8'h15, 1'b0, 8'h00, 1'b0, 8'h00);
    // R5: bit 7Fh is bit 7 of 2Fh; neighbours must survive.
    do_op(2'd0, 1'b1, 8'h2F, 1'b0, 8'h00, 1'b0, 8'h00);
    do_op(2'd3, 1'b1, 8'h7F, 1'b0, 8'h00, 1'b1, 8'h00);
    do_op(2'd0, 1'b0, 8'h2F, 1'b0, 8'h00, 1'b0, 8'h00);
    do_op(2'd3, 1'b1, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00);
    do_op(2'd0, 1'b0, 8'h20, 1'b0, 8'h00, 1'b0, 8'h00);
    // R6: bit addresses 80h and D5h go to the SFR port.
    do_op(2'd3, 1'b1, 8'h80, 1'b0, 8'h00, 1'b1, 8'h00);
    do_op(2'd3, 1'b0, 8'hD5, 1'b0, 8'h00, 1'b0, 8'h00);
    // R9: idle with write enable, then read back the byte it names.
    do_idle(8'h2F, 8'hFF);
    do_op(2'd0, 1'b0, 8'h2F, 1'b0, 8'h00, 1'b0, 8'h00);

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 9) == 0) do_idle(8'($urandom), 8'($urandom));
      else do_op(2'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
                 8'($urandom), 1'($urandom), 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule